// File: doc/BRIEF.md
# BCD Watchdog Countdown Timer

This block is a software watchdog whose timeout is programmed as four BCD digits spread over two byte-wide registers. The low register holds hundredths and tenths of a second. The high register holds units and tens of seconds. Together they give a period from 0.01 s to 99.99 s. Every read or write of either register restarts a hidden down-counter from the whole stored value. The counter then loses one hundredth on each pulse of a 100 Hz tick supplied from outside the block.

When the counter reaches zero, the watchdog flag is set. The flag also serves as the internal watchdog interrupt. That interrupt reaches the interrupt pin only when the routing bit selects the watchdog and the watchdog mask bit is clear. Firmware keeps the flag from ever setting by touching either register before the period runs out. Storing zero in both registers turns the watchdog off.

Top module: `wdog_bcd_timer`

## Requirements
- R1: After reset, flag_o and int_o are 0 and both registers read 00h.
- R2: A read returns the byte last written to the addressed register, never the live count: sel_i=0 addresses the low register (bits 7:4 tenths, bits 3:0 hundredths), sel_i=1 the high register (bits 7:4 tens of seconds, bits 3:0 seconds).
- R3: Any cycle with acc_i=1, read or write, to either register reloads the counter from the full stored value (including the byte being written) and clears flag_o at that clock edge.
- R4: With a nonzero value V (the decimal value of the four BCD digits) and no access in between, flag_o rises at the clock edge of the V-th cycle with tick_i=1, with BCD borrow across digits and across the two registers; cycles with tick_i=0 change nothing.
- R5: After expiry the counter stays at zero and flag_o stays 1 until the next register access, whatever further ticks arrive.
- R6: int_o equals flag_o while route_wd_i=1 and mask_wd_i=0, and is 0 otherwise.
- R7: While both registers hold 00h, flag_o never sets, however many ticks arrive.
- R8: An access in the same cycle as a tick takes priority: the counter is reloaded and that tick is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 Hz count enable, one cycle per pulse |
| acc_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | 1 | 0 = low register, 1 = high register |
| wdata_i | input | 8 | Write data, two BCD digits |
| rdata_o | output | 8 | Stored value of the selected register |
| route_wd_i | input | 1 | 1 routes the watchdog interrupt to int_o |
| mask_wd_i | input | 1 | 1 masks the watchdog interrupt from int_o |
| flag_o | output | 1 | Watchdog flag and internal interrupt |
| int_o | output | 1 | Interrupt pin level, active high |

## Verification
The live count is hidden, so a wrong count can only show up in the timing of flag_o. The bench therefore counts the exact tick at which the flag rises, and checks that the flag is still low one tick earlier. A borrow mistake between digits or between the two registers moves expiry by tens or hundreds of ticks, so timeouts of 0.10 s, 1.00 s and 99.99 s are used to expose it at the first expiry. A reload that misses a read, a write, or a tick in the same cycle shows up as a flag that rises during a periodic service loop. A counter that does not hold at zero shows up as a flag that fails to stay set.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;
  localparam bcd_t BCD_MAX = 4'd9;
endpackage

// File: rtl/wdog_bcd_digit.sv
module wdog_bcd_digit
  import wdog_pkg::*;
(
  input  bcd_t d_i,
  input  logic borrow_i,
  output bcd_t d_o,
  output logic borrow_o
);
  always_comb begin
    d_o      = d_i;
    borrow_o = 1'b0;
    if (borrow_i) begin
      if (d_i == '0) begin
        d_o      = BCD_MAX;
        borrow_o = 1'b1;
      end else begin
        d_o = d_i - bcd_t'(1);
      end
    end
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int REG_W    = 8,
  parameter int NUM_REGS = 2,
  parameter int SEL_W    = 1,
  localparam int TOT_W   = REG_W * NUM_REGS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [TOT_W-1:0] timeout_o,
  output logic [TOT_W-1:0] timeout_next_o
);
  logic [REG_W-1:0] regs_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit;
    assign hit = acc_i && we_i && (sel_i == SEL_W'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_q[r] <= '0;
      else if (hit) regs_q[r] <= wdata_i;
    end

    assign timeout_o[r*REG_W +: REG_W]      = regs_q[r];
    // value the counter must load this cycle, write data included
    assign timeout_next_o[r*REG_W +: REG_W] = hit ? wdata_i : regs_q[r];
  end

  assign rdata_o = regs_q[sel_i];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  localparam int CNT_W     = NUM_DIGITS * DIGIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             enable_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0]  count_q, count_dec;
  logic [NUM_DIGITS:0] borrow;
  logic step;

  assign step      = tick_i && enable_i && (count_q != '0);
  assign borrow[0] = step;

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    wdog_bcd_digit u_digit (
      .d_i      (count_q[d*DIGIT_W +: DIGIT_W]),
      .borrow_i (borrow[d]),
      .d_o      (count_dec[d*DIGIT_W +: DIGIT_W]),
      .borrow_o (borrow[d+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (load_i) count_q <= load_val_i;
    else if (step)   count_q <= count_dec;
  end

  assign count_o  = count_q;
  assign expire_o = step && !load_i && (count_q == CNT_W'(1));
endmodule

// File: rtl/wdog_bcd_timer.sv
module wdog_bcd_timer #(
  parameter int NUM_DIGITS = 4,
  parameter int REG_W      = 8,
  localparam int CNT_W     = NUM_DIGITS * wdog_pkg::DIGIT_W,
  localparam int NUM_REGS  = CNT_W / REG_W,
  localparam int SEL_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             acc_i,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             route_wd_i,
  input  logic             mask_wd_i,
  output logic             flag_o,
  output logic             int_o
);
  logic [CNT_W-1:0] timeout_q, timeout_next, count_q;
  logic expire, flag_q;

  wdog_regs #(.REG_W(REG_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .acc_i, .we_i, .sel_i, .wdata_i, .rdata_o,
    .timeout_o      (timeout_q),
    .timeout_next_o (timeout_next)
  );

  wdog_counter #(.NUM_DIGITS(NUM_DIGITS)) u_cnt (
    .clk_i, .rst_ni,
    .load_i     (acc_i),
    .load_val_i (timeout_next),
    .tick_i,
    .enable_i   (timeout_q != '0),
    .count_o    (count_q),
    .expire_o   (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (acc_i)  flag_q <= 1'b0;
    else if (expire) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
  assign int_o  = flag_q && route_wd_i && !mask_wd_i;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             acc_i,
  input logic             we_i,
  input logic             route_wd_i,
  input logic             mask_wd_i,
  input logic             flag_o,
  input logic             int_o,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] timeout_q
);
  assert_access_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> !flag_o);

  assert_read_reloads_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !we_i) |=> count_q == $past(timeout_q));

  assert_idle_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !acc_i) |=> ($stable(count_q) && $stable(flag_o)));

  assert_rise_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> ($past(tick_i) && count_q == '0));

  assert_hold_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !acc_i) |=> (flag_o && count_q == '0));

  assert_pin_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (flag_o && route_wd_i && !mask_wd_i));

  assert_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_q == '0) |-> !flag_o);
endmodule

bind wdog_bcd_timer wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .acc_i      (acc_i),
  .we_i       (we_i),
  .route_wd_i (route_wd_i),
  .mask_wd_i  (mask_wd_i),
  .flag_o     (flag_o),
  .int_o      (int_o),
  .count_q    (count_q),
  .timeout_q  (timeout_q)
);

// File: tb/wdog_bcd_timer_tb.sv
module wdog_bcd_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SIG_FLAG = 0, SIG_INT = 1, SIG_RDATA = 2;

  typedef struct {
    int         sig;
    logic [7:0] exp;
    string      req;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, acc = 1'b0, we = 1'b0, sel = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic route = 1'b1, mask = 1'b0;
  logic flag, intr;

  item_t sb_q[$];
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_bcd_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .acc_i(acc), .we_i(we),
    .sel_i(sel), .wdata_i(wdata), .rdata_o(rdata),
    .route_wd_i(route), .mask_wd_i(mask), .flag_o(flag), .int_o(intr)
  );

  // monitor: compare queued expectations away from the active edge
  initial forever begin
    @(negedge clk);
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.sig)
        SIG_FLAG: act = {7'b0, flag};
        SIG_INT:  act = {7'b0, intr};
        default:  act = rdata;
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: sig %0d actual %0h expected %0h", it.req, it.sig, act, it.exp);
      end
    end
  end

  task automatic expect_now(int sig, logic [7:0] exp, string req);
    item_t it;
    it.sig = sig; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(logic s, logic [7:0] d);
    @(posedge clk); #1;
    acc = 1; we = 1; sel = s; wdata = d;
    @(posedge clk); #1;
    acc = 0; we = 0;
  endtask

  task automatic rd(logic s, logic [7:0] exp, string req, bit with_tick = 0);
    item_t it;
    @(posedge clk); #1;
    acc = 1; we = 0; sel = s; tick = with_tick;
    it.sig = SIG_RDATA; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    @(posedge clk); #1;
    acc = 0; tick = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tick = 1;
      @(posedge clk); #1; tick = 0;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    expect_now(SIG_FLAG, 0, "R1");
    expect_now(SIG_INT, 0, "R1");
    rd(0, 8'h00, "R1");
    rd(1, 8'h00, "R1");

    // R2 / R4: 0.05 s, high register written first
    wr(1, 8'h00);
    wr(0, 8'h05);
    rd(0, 8'h05, "R2");
    rd(1, 8'h00, "R2");
    ticks(4);
    expect_now(SIG_FLAG, 0, "R4");
    ticks(1);
    expect_now(SIG_FLAG, 1, "R4");
    expect_now(SIG_INT, 1, "R6");
    mask = 1;
    expect_now(SIG_INT, 0, "R6");
    mask = 0; route = 0;
    expect_now(SIG_INT, 0, "R6");
    route = 1;

    // R5 flag holds across further ticks
    ticks(7);
    expect_now(SIG_FLAG, 1, "R5");

    // R3 read clears and reloads
    rd(1, 8'h00, "R3");
    expect_now(SIG_FLAG, 0, "R3");
    ticks(4);
    expect_now(SIG_FLAG, 0, "R3");
    ticks(1);
    expect_now(SIG_FLAG, 1, "R3");

    // R3 periodic service keeps the flag low
    rd(0, 8'h05, "R3");
    for (int k = 0; k < 3; k++) begin
      ticks(3);
      rd(k[0], k[0] ? 8'h00 : 8'h05, "R3");
    end
    ticks(4);
    expect_now(SIG_FLAG, 0, "R3");
    ticks(1);
    expect_now(SIG_FLAG, 1, "R3");

    // R8 access wins over a simultaneous tick
    rd(0, 8'h05, "R8");
    ticks(2);
    rd(0, 8'h05, "R8", 1);
    ticks(4);
    expect_now(SIG_FLAG, 0, "R8");
    ticks(1);
    expect_now(SIG_FLAG, 1, "R8");

    // R4 borrow from tenths: 0.10 s, low register written first
    wr(0, 8'h10);
    expect_now(SIG_FLAG, 0, "R3");
    wr(1, 8'h00);
    ticks(9);
    expect_now(SIG_FLAG, 0, "R4");
    ticks(1);
    expect_now(SIG_FLAG, 1, "R4");

    // R4 borrow across registers: 1.00 s
    wr(0, 8'h00);
    wr(1, 8'h01);
    ticks(99);
    expect_now(SIG_FLAG, 0, "R4");
    ticks(1);
    expect_now(SIG_FLAG, 1, "R4");

    // R4 full range: 99.99 s
    wr(1, 8'h99);
    wr(0, 8'h99);
    rd(1, 8'h99, "R2");
    ticks(9998);
    expect_now(SIG_FLAG, 0, "R4");
    ticks(1);
    expect_now(SIG_FLAG, 1, "R4");

    // R7 zero disables
    wr(1, 8'h00);
    wr(0, 8'h00);
    ticks(50);
    expect_now(SIG_FLAG, 0, "R7");
    expect_now(SIG_INT, 0, "R7");
    rd(0, 8'h00, "R7");

    done = 1;
    summary();
  end
endmodule